// File: doc/BRIEF.md
# Halt, Wake-Up and Reset Controller

This block sequences a processor core through low-power halt, wake-up and reset. A halt strobe from the instruction decoder turns off the system oscillator, clears the watchdog and sets the power-down flag. While halted, the block watches four wake sources: the external reset pin, the watchdog overflow, an interrupt request, and a falling edge on any enabled bit of an input port. It classifies each wake or reset into a cold reset (full initialisation) or a warm reset (program counter and stack pointer only), and keeps a time-out flag and a power-down flag from which software can tell the cause afterwards.

After power-up and after every wake from halt, the core is held for a fixed start-up interval while the oscillator settles. When a wake by port edge or interrupt finishes that interval, the block pulses a resume indication and tells the core whether to take the interrupt or to go on with the next instruction. The interrupt is taken only when it is enabled and the return stack has room. An interrupt whose request was already pending when the halt began cannot wake the core until that request has been withdrawn.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `cold_rst_o` is 1 and both `to_o` and `pdf_o` are 0. After `rst_n` rises, `osc_en_o` is 1 and `cpu_hold_o` stays 1 for exactly `WARMUP_CYCLES` cycles.
- R2: A `halt_i` strobe while running sets `osc_en_o` to 0, `pdf_o` to 1 and `to_o` to 0, and pulses `wdt_clr_o` for one cycle. All of these show on the cycle after the strobe.
- R3: A `clr_wdt_i` strobe while running clears `pdf_o` and leaves `to_o` unchanged.
- R4: A `wdt_timeout_i` while running sets `to_o` to 1, leaves `pdf_o` unchanged, pulses `cold_rst_o`, and adds no start-up hold. It takes precedence over a `halt_i` in the same cycle, and the core stays running.
- R5: A `wdt_timeout_i` while halted sets both `to_o` and `pdf_o` to 1, pulses `warm_rst_o` (and not `cold_rst_o`), turns the oscillator on and starts the start-up hold.
- R6: An `ext_rst_i` while halted sets `to_o` to 0 and `pdf_o` to 1, pulses `cold_rst_o` and starts the start-up hold, and no resume pulse follows. While running, `ext_rst_i` pulses `cold_rst_o`, leaves both flags unchanged and adds no hold.
- R7: While halted, a 1-to-0 transition on `port_i[b]` wakes the core when `port_wake_en_i[b]` is 1. The edge takes effect after the synchroniser delay. A transition on a bit whose enable is 0 leaves the oscillator off.
- R8: While halted, `irq_req_i` at 1 wakes the core. When the start-up hold ends, `resume_take_irq_o` is 1 only if `irq_en_i` is 1 and `stack_full_i` is 0. Otherwise it is 0, and `resume_o` is 1 either way.
- R9: If `irq_req_i` is 1 at the halt strobe, it cannot wake the core. Once the request drops to 0 during the halt, a new request wakes the core again.
- R10: Every wake holds `cpu_hold_o` at 1 for exactly `WARMUP_CYCLES` cycles after the oscillator turns on. A port or interrupt wake then gives a one-cycle `resume_o` in the first running cycle.
- R11: When several wake sources arrive in the same cycle while halted, they rank reset pin first, then watchdog, then interrupt, then port edge. The highest-ranked source alone sets the flags, the reset pulse and the resume decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, always running |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| halt_i | input | 1 | One-cycle halt strobe from the decoder |
| clr_wdt_i | input | 1 | One-cycle clear-watchdog strobe from the decoder |
| ext_rst_i | input | 1 | External reset pin request, active high, synchronous |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| port_i | input | PORT_W | Raw input port pins |
| port_wake_en_i | input | PORT_W | Per-bit falling-edge wake enables |
| irq_req_i | input | 1 | Combined interrupt request |
| irq_en_i | input | 1 | Interrupt enable of the requesting source |
| stack_full_i | input | 1 | Return stack full |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |
| cold_rst_o | output | 1 | Full initialisation request |
| warm_rst_o | output | 1 | Program counter and stack pointer reset request |
| wdt_clr_o | output | 1 | Watchdog clear pulse on halt entry |
| osc_en_o | output | 1 | System oscillator enable |
| cpu_hold_o | output | 1 | Core stall during halt and start-up |
| resume_o | output | 1 | One-cycle pulse when a port or interrupt wake completes |
| resume_take_irq_o | output | 1 | With resume_o: 1 vectors to the interrupt, 0 continues |

## Verification
The collision the bench provokes most deliberately is a watchdog time-out in the same cycle as a halt strobe. Both strobes are raised on one falling clock edge. The check on the following falling edge expects the time-out to win: the oscillator stays on, there is no hold, `to_o` is 1, `pdf_o` keeps its earlier value and `cold_rst_o` is 1. The halted-state collisions are also forced in a single cycle: reset pin with watchdog, watchdog with interrupt, and interrupt with port edge. Each is judged by which reset pulse appears, by the flag pair, and by whether a resume pulse, and which resume decision, follows the start-up hold.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
   typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_WARMUP} hwc_state_e;
   typedef enum logic [1:0] {WK_RESET, WK_PORT, WK_IRQ} hwc_wake_e;
   typedef enum logic [2:0] {
      EV_NONE, EV_HALT, EV_CLRWD, EV_WD_RUN, EV_WD_HALT, EV_PIN_HALT
   } hwc_event_e;
endpackage

// File: rtl/hwc_pin_edge.sv
module hwc_pin_edge #(
   parameter int PORT_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pin_i,
   input  logic [PORT_W-1:0] en_i,
   output logic [PORT_W-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hwc_pin_edge: STAGES must be at least 2");
   end
   if (PORT_W < 1) begin : g_bad_width
      $error("hwc_pin_edge: PORT_W must be at least 1");
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh   <= '1;
            prev <= 1'b1;
         end else begin
            sh   <= {sh[STAGES-2:0], pin_i[i]};
            prev <= sh[STAGES-1];
         end
      end

      assign fall_o[i] = prev & ~sh[STAGES-1] & en_i[i];

      // R7: a detected edge lasts exactly one cycle
      assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
         fall_o[i] |=> !fall_o[i]);
   end
endmodule

// File: rtl/hwc_warmup_timer.sv
module hwc_warmup_timer #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic en_i,
   output logic done_o
);
   localparam int              CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0]   LAST = CW'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("hwc_warmup_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load_i)            cnt <= '0;
      else if (en_i && !done_o)   cnt <= cnt + CW'(1);
   end

   assign done_o = (cnt == LAST);

   // R10: the count never runs past the last hold cycle
   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R10: a counting cycle advances by exactly one
   assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !load_i && !done_o) |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/hwc_flags.sv
module hwc_flags
   import hwc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  hwc_event_e ev_i,
   output logic       to_o,
   output logic       pdf_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_o  <= 1'b0;
         pdf_o <= 1'b0;
      end else begin
         unique case (ev_i)
            EV_HALT, EV_PIN_HALT: begin to_o <= 1'b0; pdf_o <= 1'b1; end
            EV_CLRWD:             pdf_o <= 1'b0;
            EV_WD_RUN:            to_o  <= 1'b1;
            EV_WD_HALT:           begin to_o <= 1'b1; pdf_o <= 1'b1; end
            default: ;
         endcase
      end
   end

   // R5: watchdog wake from halt leaves the pair at 1,1
   assert_wd_halt_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_WD_HALT |=> to_o && pdf_o);
   // R3: clear-watchdog keeps the time-out flag
   assert_clrwd_keeps_to_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_CLRWD |=> !pdf_o && to_o == $past(to_o));
   // R4: time-out while running keeps the power-down flag
   assert_wd_run_keeps_pdf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i == EV_WD_RUN |=> to_o && pdf_o == $past(pdf_o));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
   import hwc_pkg::*;
#(
   parameter int PORT_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int WARMUP_CYCLES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              clr_wdt_i,
   input  logic              ext_rst_i,
   input  logic              wdt_timeout_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [PORT_W-1:0] port_wake_en_i,
   input  logic              irq_req_i,
   input  logic              irq_en_i,
   input  logic              stack_full_i,
   output logic              to_o,
   output logic              pdf_o,
   output logic              cold_rst_o,
   output logic              warm_rst_o,
   output logic              wdt_clr_o,
   output logic              osc_en_o,
   output logic              cpu_hold_o,
   output logic              resume_o,
   output logic              resume_take_irq_o
);
   hwc_state_e        state, state_n;
   hwc_wake_e         kind, kind_n;
   hwc_event_e        ev;
   logic              blk, blk_n;
   logic              load, done;
   logic              cold_n, warm_n, clr_n, res_n, take_n;
   logic [PORT_W-1:0] fall;

   hwc_pin_edge #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(port_i), .en_i(port_wake_en_i), .fall_o(fall));

   hwc_warmup_timer #(.CYCLES(WARMUP_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .load_i(load), .en_i(state == ST_WARMUP), .done_o(done));

   hwc_flags i_flags (.clk(clk), .rst_n(rst_n), .ev_i(ev), .to_o(to_o), .pdf_o(pdf_o));

   always_comb begin
      state_n = state;
      kind_n  = kind;
      blk_n   = blk;
      ev      = EV_NONE;
      load    = 1'b0;
      cold_n  = 1'b0;
      warm_n  = 1'b0;
      clr_n   = 1'b0;
      res_n   = 1'b0;
      take_n  = 1'b0;
      unique case (state)
         ST_RUN: begin
            if (ext_rst_i) begin
               cold_n = 1'b1;
            end else if (wdt_timeout_i) begin
               ev     = EV_WD_RUN;
               cold_n = 1'b1;
            end else if (halt_i) begin
               ev      = EV_HALT;
               state_n = ST_HALT;
               clr_n   = 1'b1;
               blk_n   = irq_req_i;
            end else if (clr_wdt_i) begin
               ev = EV_CLRWD;
            end
         end
         ST_HALT: begin
            if (!irq_req_i) blk_n = 1'b0;
            if (ext_rst_i) begin
               ev      = EV_PIN_HALT;
               cold_n  = 1'b1;
               state_n = ST_WARMUP;
               kind_n  = WK_RESET;
               load    = 1'b1;
            end else if (wdt_timeout_i) begin
               ev      = EV_WD_HALT;
               warm_n  = 1'b1;
               state_n = ST_WARMUP;
               kind_n  = WK_RESET;
               load    = 1'b1;
            end else if (irq_req_i && !blk) begin
               state_n = ST_WARMUP;
               kind_n  = WK_IRQ;
               load    = 1'b1;
            end else if (|fall) begin
               state_n = ST_WARMUP;
               kind_n  = WK_PORT;
               load    = 1'b1;
            end
         end
         ST_WARMUP: begin
            if (ext_rst_i) begin
               cold_n = 1'b1;
               kind_n = WK_RESET;
               load   = 1'b1;
            end else if (done) begin
               state_n = ST_RUN;
               res_n   = (kind != WK_RESET);
               take_n  = (kind == WK_IRQ) && irq_en_i && !stack_full_i;
            end
         end
         default: state_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state             <= ST_WARMUP;
         kind              <= WK_RESET;
         blk               <= 1'b0;
         cold_rst_o        <= 1'b1;
         warm_rst_o        <= 1'b0;
         wdt_clr_o         <= 1'b0;
         resume_o          <= 1'b0;
         resume_take_irq_o <= 1'b0;
      end else begin
         state             <= state_n;
         kind              <= kind_n;
         blk               <= blk_n;
         cold_rst_o        <= cold_n;
         warm_rst_o        <= warm_n;
         wdt_clr_o         <= clr_n;
         resume_o          <= res_n;
         resume_take_irq_o <= take_n;
      end
   end

   assign osc_en_o   = (state != ST_HALT);
   assign cpu_hold_o = (state != ST_RUN);

   // R5: a warm reset always carries the 1,1 flag pair
   assert_warm_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_o |-> to_o && pdf_o && !cold_rst_o);
   // R8: the vector decision is only given with a resume
   assert_take_with_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_take_irq_o |-> resume_o);
   // R10: resume comes in the first cycle after the hold ends
   assert_resume_after_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> !cpu_hold_o && $past(cpu_hold_o));
   // R2: the watchdog clear goes with oscillator off and power-down set
   assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr_o |-> !osc_en_o && pdf_o && !to_o);
endmodule

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;
   localparam int W  = 4;
   localparam int NW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt = 0, clrwd = 0, xrst = 0, wdt = 0, irq = 0, ien = 0, sfull = 0;
   logic [W-1:0] pins = '1, wen = '0;
   logic to_f, pdf_f, cold, warm, wclr, osc, hold, res, take;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   halt_wake_ctrl #(.PORT_W(W), .SYNC_STAGES(2), .WARMUP_CYCLES(NW)) i_halt_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .halt_i(halt), .clr_wdt_i(clrwd), .ext_rst_i(xrst),
      .wdt_timeout_i(wdt), .port_i(pins), .port_wake_en_i(wen), .irq_req_i(irq),
      .irq_en_i(ien), .stack_full_i(sfull), .to_o(to_f), .pdf_o(pdf_f),
      .cold_rst_o(cold), .warm_rst_o(warm), .wdt_clr_o(wclr), .osc_en_o(osc),
      .cpu_hold_o(hold), .resume_o(res), .resume_take_irq_o(take));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic count_hold(output int n);
      n = 0;
      while (hold === 1'b1 && n < 10000) begin n++; step(); end
   endtask

   task automatic enter_halt();
      halt = 1; step(); halt = 0;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int n;
      // R1 power-up
      repeat (3) step();
      chk("R1 cold during reset", cold, 1);
      chk("R1 flags during reset", {to_f, pdf_f}, 0);
      rst_n = 1;
      count_hold(n);
      chk("R1 power-up hold length", n, NW);
      chk("R1 osc on", osc, 1);
      chk("R1 cold released", cold, 0);
      chk("R10 no resume after power-up", res, 0);

      // R2 halt, R6 pin wake from halt
      enter_halt();
      chk("R2 osc off", osc, 0);
      chk("R2 flags 0,1", {to_f, pdf_f}, 1);
      chk("R2 watchdog clear pulse", wclr, 1);
      step();
      chk("R2 watchdog clear one cycle", wclr, 0);
      chk("R2 still held", hold, 1);
      xrst = 1; step(); xrst = 0;
      chk("R6 cold on pin wake", cold, 1);
      chk("R6 flags 0,1", {to_f, pdf_f}, 1);
      chk("R6 osc on", osc, 1);
      count_hold(n);
      chk("R6 hold length", n, NW);
      chk("R6 no resume", res, 0);

      // R4 time-out while running
      wdt = 1; step(); wdt = 0;
      chk("R4 flags 1,1 (pdf kept)", {to_f, pdf_f}, 3);
      chk("R4 cold pulse", cold, 1);
      chk("R4 no hold", hold, 0);

      // R3 clear-watchdog
      clrwd = 1; step(); clrwd = 0;
      chk("R3 flags 1,0", {to_f, pdf_f}, 2);

      // R4 time-out beats halt in same cycle
      wdt = 1; halt = 1; step(); wdt = 0; halt = 0;
      chk("R4 collision flags 1,0", {to_f, pdf_f}, 2);
      chk("R4 collision stays running", {osc, hold}, 2);
      chk("R4 collision cold", cold, 1);
      chk("R4 collision no watchdog clear", wclr, 0);

      // R6 pin while running
      xrst = 1; step(); xrst = 0;
      chk("R6 run cold pulse", cold, 1);
      chk("R6 run flags unchanged", {to_f, pdf_f}, 2);
      chk("R6 run no hold", hold, 0);

      // R5 watchdog wake from halt
      enter_halt();
      wdt = 1; step(); wdt = 0;
      chk("R5 flags 1,1", {to_f, pdf_f}, 3);
      chk("R5 warm pulse", warm, 1);
      chk("R5 no cold", cold, 0);
      chk("R5 osc on", osc, 1);
      count_hold(n);
      chk("R5 hold length", n, NW);
      chk("R5 no resume", res, 0);

      // R7 port sweep
      for (int b = 0; b < W; b++) begin
         for (int e = 0; e < 2; e++) begin
            wen = (e != 0) ? W'(1 << b) : ~W'(1 << b);
            enter_halt();
            pins[b] = 1'b0;
            n = 0;
            while (osc !== 1'b1 && n < 6) begin step(); n++; end
            if (e != 0) begin
               chk($sformatf("R7 bit %0d wake latency", b), n, 3);
               count_hold(n);
               chk($sformatf("R10 bit %0d hold length", b), n, NW);
               chk($sformatf("R10 bit %0d resume", b), {res, take}, 2);
               step();
               chk("R10 resume one cycle", res, 0);
            end else begin
               chk($sformatf("R7 bit %0d masked stays halted", b), osc, 0);
               xrst = 1; step(); xrst = 0;
               count_hold(n);
            end
            pins = '1; wen = '0;
            repeat (4) step();
         end
      end

      // R8 interrupt sweep
      for (int c = 0; c < 4; c++) begin
         ien = c[0]; sfull = c[1];
         enter_halt();
         irq = 1; step();
         chk("R8 interrupt wakes", osc, 1);
         count_hold(n);
         chk("R8 hold length", n, NW);
         chk($sformatf("R8 en=%0d full=%0d decision", c[0], c[1]),
             {res, take}, (c[0] && !c[1]) ? 3 : 2);
         irq = 0; step();
      end

      // R9 pending request blocks wake
      ien = 1; sfull = 0;
      irq = 1; enter_halt();
      repeat (5) step();
      chk("R9 pending request no wake", osc, 0);
      irq = 0; step(); step();
      chk("R9 still halted after drop", osc, 0);
      irq = 1; step();
      chk("R9 new request wakes", osc, 1);
      count_hold(n);
      chk("R9 vectors", {res, take}, 3);
      irq = 0; step();

      // R11 priorities in halt
      enter_halt();
      xrst = 1; wdt = 1; step(); xrst = 0; wdt = 0;
      chk("R11 pin over watchdog", {cold, warm}, 2);
      chk("R11 pin flags 0,1", {to_f, pdf_f}, 1);
      count_hold(n);

      enter_halt();
      wdt = 1; irq = 1; step(); wdt = 0;
      chk("R11 watchdog over interrupt", {cold, warm}, 1);
      count_hold(n);
      chk("R11 no resume after warm", res, 0);
      irq = 0; step();

      wen = '1;
      enter_halt();
      irq = 1; pins[0] = 1'b0; step();
      chk("R11 interrupt over port wakes", osc, 1);
      count_hold(n);
      chk("R11 interrupt kind wins", {res, take}, 3);
      irq = 0; pins = '1; wen = '0;
      repeat (4) step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule